// File: doc/BRIEF.md
# Snoop-Address Channel Network Interface

This block joins one coherent-channel port to the Local port of a mesh router. On its transmit side it takes one snoop-address beat (address, snoop type, protection bits, transaction ID) under a valid/ready handshake. It turns the beat into a short packet of 32-bit flits. The first flit is a header carrying the ID of the router this interface hangs on, the ID of the router that owns the addressed slave, and the transaction ID. The flits that follow carry the address. The destination comes from a parameterised table of address ranges, and an address that hits none of them goes to a default router.

On its receive side the block takes flits from the router, rebuilds the same beat from the header and the address flits, and presents the beat to the local port under its own valid/ready handshake. Each direction handles one packet at a time. Ordering rules, snoop decisions and route selection belong to other blocks.

Top module: `snp_ni`

## Requirements
- R1: The header flit is laid out as bits [3:0] source router ID (the parameter NODE_ID, default 3), [7:4] destination router ID, [11:8] transaction ID, [15:12] snoop type, [18:16] protection bits, and bits [31:19] zero.
- R2: The destination router ID is the ID of the address range (inclusive low and high bounds) that contains the beat's address. When ranges overlap, the lowest-numbered range wins. With the default table, 0x1000_0000..0x1FFF_FFFF gives 5, 0x0000_0000..0x3FFF_FFFF gives 8, and 0x8000_0000..0xBFFF_FFFF gives 2.
- R3: An address that falls in no range is sent to DEFAULT_ID (default 7).
- R4: The transaction ID in the header is the beat's ID field, copied unchanged.
- R5: A packet for a 32-bit address is two flits. The header is flit one, with the first flag set and the last flag clear. The address is flit two, with the last flag set and the first flag clear.
- R6: While the router holds flit-ready low, the offered flit, including its data and flags, stays unchanged and stays valid.
- R7: The transmit side accepts a new beat only when no flit of an earlier packet is still pending. Beat-ready is high out of reset and again in the cycle after the last flit is taken, and it is low from the accepting edge until then.
- R8: The receive side raises beat-valid only after taking a flit with the last flag set. It then presents the address, snoop type, protection bits, transaction ID and source ID taken from the packet. Idle cycles between flits do not disturb reassembly.
- R9: The received beat stays valid and unchanged until beat-ready is high. While it is held, flit-ready is low, and flits offered in that time are not taken.
- R10: After reset, the transmit flit valid and receive beat valid are low, and beat-ready and flit-ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Outgoing beat valid |
| tx_ready | output | 1 | Outgoing beat accepted |
| tx_addr | input | ADDR_W | Snoop address |
| tx_snp | input | 4 | Snoop type |
| tx_prot | input | 3 | Protection bits |
| tx_tid | input | 4 | Transaction ID |
| txf_valid | output | 1 | Flit to router valid |
| txf_ready | input | 1 | Router takes flit |
| txf_data | output | 32 | Flit to router |
| txf_first | output | 1 | Flit starts a packet |
| txf_last | output | 1 | Flit ends a packet |
| rxf_valid | input | 1 | Flit from router valid |
| rxf_ready | output | 1 | Interface takes flit |
| rxf_data | input | 32 | Flit from router |
| rxf_first | input | 1 | Flit starts a packet |
| rxf_last | input | 1 | Flit ends a packet |
| rx_valid | output | 1 | Rebuilt beat valid |
| rx_ready | input | 1 | Local port takes beat |
| rx_addr | output | ADDR_W | Rebuilt snoop address |
| rx_snp | output | 4 | Rebuilt snoop type |
| rx_prot | output | 3 | Rebuilt protection bits |
| rx_tid | output | 4 | Rebuilt transaction ID |
| rx_src | output | 4 | Source router of the packet |

## Verification
A wrong flit counter on the transmit side shows up within one or two cycles of an accepted beat. The flags appear on the wrong flit, the address word is sent in the header slot, or beat-ready comes back while a flit is still pending. A wrong destination decode shows up at once in bits [7:4] of the first flit. On the receive side, a hold flag that is lost or stuck shows up as beat-valid rising before the last flit, dropping under backpressure, or never clearing. A bad word index leaves a stale address on the very beat that follows.

// File: rtl/snp_ni_pkg.sv
package snp_ni_pkg;
    localparam int unsigned FLIT_W = 32;
    localparam int unsigned NID_W  = 4;

    typedef struct packed {
        logic [12:0]      pad;
        logic [2:0]       prot;
        logic [3:0]       snp;
        logic [NID_W-1:0] tid;
        logic [NID_W-1:0] dst;
        logic [NID_W-1:0] src;
    } hdr_t;
endpackage

// File: rtl/ni_addr_map.sv
module ni_addr_map
    import snp_ni_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned NREG   = 3,
    parameter logic [NREG-1:0][ADDR_W-1:0] RGN_LO = '0,
    parameter logic [NREG-1:0][ADDR_W-1:0] RGN_HI = '0,
    parameter logic [NREG-1:0][NID_W-1:0]  RGN_ID = '0,
    parameter logic [NID_W-1:0] DEFAULT_ID = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NID_W-1:0]  dst
);
    // scan from the top so the lowest matching index is the last to write
    always_comb begin
        dst = DEFAULT_ID;
        for (int i = int'(NREG) - 1; i >= 0; i--) begin
            if (addr >= RGN_LO[i] && addr <= RGN_HI[i]) begin
                dst = RGN_ID[i];
            end
        end
    end
endmodule

// File: rtl/ni_pktz.sv
module ni_pktz
    import snp_ni_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter logic [NID_W-1:0] NODE_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [3:0]        in_snp,
    input  logic [2:0]        in_prot,
    input  logic [NID_W-1:0]  in_tid,
    input  logic [NID_W-1:0]  in_dst,
    output logic              fl_valid,
    input  logic              fl_ready,
    output logic [FLIT_W-1:0] fl_data,
    output logic              fl_first,
    output logic              fl_last
);
    localparam int unsigned AWORDS = (ADDR_W + FLIT_W - 1) / FLIT_W;
    localparam int unsigned NFLITS = AWORDS + 1;
    localparam int unsigned CNT_W  = $clog2(NFLITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NFLITS - 1);

    typedef struct packed {
        logic                           busy;
        logic [CNT_W-1:0]               idx;
        logic [NFLITS-1:0][FLIT_W-1:0]  flits;
    } st_t;

    st_t st_d, st_q;
    hdr_t hdr;
    logic [AWORDS*FLIT_W-1:0] apad;

    always_comb begin
        hdr      = '0;
        hdr.src  = NODE_ID;
        hdr.dst  = in_dst;
        hdr.tid  = in_tid;
        hdr.snp  = in_snp;
        hdr.prot = in_prot;
        apad     = '0;
        apad[ADDR_W-1:0] = in_addr;

        st_d = st_q;
        if (st_q.busy) begin
            if (fl_ready) begin
                if (st_q.idx == LAST_IDX) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end else if (in_valid) begin
            st_d.busy     = 1'b1;
            st_d.idx      = '0;
            st_d.flits[0] = hdr;
            for (int w = 0; w < int'(AWORDS); w++) begin
                st_d.flits[w+1] = apad[w*FLIT_W +: FLIT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = !st_q.busy;
    assign fl_valid = st_q.busy;
    assign fl_data  = st_q.flits[st_q.idx];
    assign fl_first = (st_q.idx == '0);
    assign fl_last  = (st_q.idx == LAST_IDX);

    // R6
    fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid && !fl_ready |=> fl_valid && $stable(fl_data) && $stable(fl_last))
        else $error("offered flit changed under backpressure");

    // R7
    reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid && fl_ready && fl_last |=> in_ready && !fl_valid)
        else $error("beat side not reopened after last flit");

    // R5
    lead_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_valid) |-> fl_first && !fl_last)
        else $error("packet did not start with header flit");
endmodule

// File: rtl/ni_depktz.sv
module ni_depktz
    import snp_ni_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_valid,
    output logic              fl_ready,
    input  logic [FLIT_W-1:0] fl_data,
    input  logic              fl_first,
    input  logic              fl_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [3:0]        out_snp,
    output logic [2:0]        out_prot,
    output logic [NID_W-1:0]  out_tid,
    output logic [NID_W-1:0]  out_src
);
    localparam int unsigned AWORDS = (ADDR_W + FLIT_W - 1) / FLIT_W;
    localparam int unsigned WI_W   = $clog2(AWORDS + 1);

    typedef struct packed {
        logic                           hold;
        logic [WI_W-1:0]                widx;
        hdr_t                           hdr;
        logic [AWORDS-1:0][FLIT_W-1:0]  words;
    } st_t;

    st_t st_d, st_q;
    logic [AWORDS*FLIT_W-1:0] flat;

    always_comb begin
        st_d = st_q;
        if (st_q.hold) begin
            if (out_ready) begin
                st_d.hold = 1'b0;
            end
        end else if (fl_valid) begin
            if (fl_first) begin
                st_d.hdr  = fl_data;
                st_d.widx = '0;
            end else begin
                if (st_q.widx < WI_W'(AWORDS)) begin
                    st_d.words[st_q.widx] = fl_data;
                end
                st_d.widx = st_q.widx + 1'b1;
            end
            if (fl_last) begin
                st_d.hold = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flat      = st_q.words;
    assign fl_ready  = !st_q.hold;
    assign out_valid = st_q.hold;
    assign out_addr  = flat[ADDR_W-1:0];
    assign out_snp   = st_q.hdr.snp;
    assign out_prot  = st_q.hdr.prot;
    assign out_tid   = st_q.hdr.tid;
    assign out_src   = st_q.hdr.src;

    // R8
    eop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(fl_valid && fl_last))
        else $error("beat valid without a closing flit");

    // R9
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_tid))
        else $error("rebuilt beat changed under backpressure");
endmodule

// File: rtl/snp_ni.sv
module snp_ni
    import snp_ni_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned NREG   = 3,
    parameter logic [NID_W-1:0] NODE_ID    = 4'd3,
    parameter logic [NID_W-1:0] DEFAULT_ID = 4'd7,
    parameter logic [NREG-1:0][ADDR_W-1:0] RGN_LO =
        {32'h8000_0000, 32'h0000_0000, 32'h1000_0000},
    parameter logic [NREG-1:0][ADDR_W-1:0] RGN_HI =
        {32'hBFFF_FFFF, 32'h3FFF_FFFF, 32'h1FFF_FFFF},
    parameter logic [NREG-1:0][NID_W-1:0] RGN_ID = {4'd2, 4'd8, 4'd5}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [3:0]        tx_snp,
    input  logic [2:0]        tx_prot,
    input  logic [3:0]        tx_tid,
    output logic              txf_valid,
    input  logic              txf_ready,
    output logic [31:0]       txf_data,
    output logic              txf_first,
    output logic              txf_last,
    input  logic              rxf_valid,
    output logic              rxf_ready,
    input  logic [31:0]       rxf_data,
    input  logic              rxf_first,
    input  logic              rxf_last,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [ADDR_W-1:0] rx_addr,
    output logic [3:0]        rx_snp,
    output logic [2:0]        rx_prot,
    output logic [3:0]        rx_tid,
    output logic [3:0]        rx_src
);
    logic [NID_W-1:0] dst;

    ni_addr_map #(
        .ADDR_W(ADDR_W), .NREG(NREG), .RGN_LO(RGN_LO), .RGN_HI(RGN_HI),
        .RGN_ID(RGN_ID), .DEFAULT_ID(DEFAULT_ID)
    ) u_map (
        .addr(tx_addr),
        .dst (dst)
    );

    ni_pktz #(.ADDR_W(ADDR_W), .NODE_ID(NODE_ID)) u_pktz (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(tx_valid),
        .in_ready(tx_ready),
        .in_addr (tx_addr),
        .in_snp  (tx_snp),
        .in_prot (tx_prot),
        .in_tid  (tx_tid),
        .in_dst  (dst),
        .fl_valid(txf_valid),
        .fl_ready(txf_ready),
        .fl_data (txf_data),
        .fl_first(txf_first),
        .fl_last (txf_last)
    );

    ni_depktz #(.ADDR_W(ADDR_W)) u_depktz (
        .clk      (clk),
        .rst_n    (rst_n),
        .fl_valid (rxf_valid),
        .fl_ready (rxf_ready),
        .fl_data  (rxf_data),
        .fl_first (rxf_first),
        .fl_last  (rxf_last),
        .out_valid(rx_valid),
        .out_ready(rx_ready),
        .out_addr (rx_addr),
        .out_snp  (rx_snp),
        .out_prot (rx_prot),
        .out_tid  (rx_tid),
        .out_src  (rx_src)
    );
endmodule

// File: tb/snp_ni_tb.sv
module snp_ni_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0, tx_ready;
    logic [31:0] tx_addr = '0;
    logic [3:0]  tx_snp = '0;
    logic [2:0]  tx_prot = '0;
    logic [3:0]  tx_tid = '0;
    logic        txf_valid, txf_ready = 1'b0;
    logic [31:0] txf_data;
    logic        txf_first, txf_last;
    logic        rxf_valid = 1'b0, rxf_ready;
    logic [31:0] rxf_data = '0;
    logic        rxf_first = 1'b0, rxf_last = 1'b0;
    logic        rx_valid, rx_ready = 1'b0;
    logic [31:0] rx_addr;
    logic [3:0]  rx_snp, rx_tid, rx_src;
    logic [2:0]  rx_prot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    snp_ni u_dut (.*);

    // {addr, snoop type, prot, tid, expected destination}
    localparam int NV = 8;
    localparam logic [46:0] VEC [NV] = '{
        {32'h1234_5678, 4'h1, 3'd1, 4'h2, 4'd5},   // R2 overlap priority
        {32'h0000_0040, 4'h2, 3'd2, 4'h3, 4'd8},
        {32'h3FFF_FFFF, 4'h3, 3'd3, 4'h4, 4'd8},   // R2 upper bound
        {32'h2000_0000, 4'h4, 3'd4, 4'h5, 4'd8},
        {32'h8000_0000, 4'h5, 3'd5, 4'h6, 4'd2},   // R2 lower bound
        {32'hBFFF_FFFF, 4'h6, 3'd6, 4'h7, 4'd2},
        {32'hC000_0000, 4'h7, 3'd7, 4'hE, 4'd7},   // R3
        {32'h4000_0000, 4'hF, 3'd0, 4'hF, 4'd7}    // R3
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkhdr(input logic [2:0] p, input logic [3:0] s,
            input logic [3:0] t, input logic [3:0] d, input logic [3:0] src);
        return {13'd0, p, s, t, d, src};
    endfunction

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk(!txf_valid && tx_ready && !rx_valid && rxf_ready, "R10",
            {txf_valid, tx_ready, rx_valid, rxf_ready}, 4'b0101);

        // vector table through the transmit side
        txf_ready = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [31:0] a; logic [3:0] s; logic [2:0] p; logic [3:0] t; logic [3:0] d;
            {a, s, p, t, d} = VEC[i];
            @(negedge clk);
            tx_valid = 1'b1; tx_addr = a; tx_snp = s; tx_prot = p; tx_tid = t;
            chk(tx_ready, "R7 idle ready", tx_ready, 1);
            @(negedge clk);
            tx_valid = 1'b0;
            chk(txf_valid && txf_first && !txf_last, "R5 header flags",
                {txf_valid, txf_first, txf_last}, 3'b110);
            chk(txf_data == mkhdr(p, s, t, d, 4'd3), "R1 R2 R3 R4 header",
                txf_data, mkhdr(p, s, t, d, 4'd3));
            chk(!tx_ready, "R7 busy", tx_ready, 0);
            @(negedge clk);
            chk(txf_valid && !txf_first && txf_last && txf_data == a, "R5 address flit",
                {txf_valid, txf_first, txf_last, txf_data}, {3'b101, a});
            @(negedge clk);
            chk(!txf_valid && tx_ready, "R7 reopen", {txf_valid, tx_ready}, 2'b01);
        end

        // backpressure on the flit side and a waiting second beat
        @(negedge clk);
        txf_ready = 1'b0;
        tx_valid = 1'b1; tx_addr = 32'h1000_0000; tx_snp = 4'h9; tx_prot = 3'd2; tx_tid = 4'hA;
        @(negedge clk);
        tx_addr = 32'hA000_0004; tx_snp = 4'h3; tx_prot = 3'd1; tx_tid = 4'h6;
        for (int k = 0; k < 3; k++) begin
            chk(txf_valid && txf_first && txf_data == mkhdr(3'd2, 4'h9, 4'hA, 4'd5, 4'd3),
                "R6 held header", txf_data, mkhdr(3'd2, 4'h9, 4'hA, 4'd5, 4'd3));
            chk(!tx_ready, "R7 blocked beat", tx_ready, 0);
            @(negedge clk);
        end
        txf_ready = 1'b1;
        @(negedge clk);
        chk(txf_last && txf_data == 32'h1000_0000 && !tx_ready, "R7 R5 first packet tail",
            txf_data, 32'h1000_0000);
        @(negedge clk);
        chk(!txf_valid && tx_ready, "R7 reopen after tail", {txf_valid, tx_ready}, 2'b01);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(txf_first && txf_data == mkhdr(3'd1, 4'h3, 4'h6, 4'd2, 4'd3), "R4 second beat",
            txf_data, mkhdr(3'd1, 4'h3, 4'h6, 4'd2, 4'd3));
        @(negedge clk);
        chk(txf_last && txf_data == 32'hA000_0004, "R5 second tail", txf_data, 32'hA000_0004);
        @(negedge clk);
        txf_ready = 1'b0;

        // receive side: header, idle gap, address flit
        rx_ready = 1'b0;
        rxf_valid = 1'b1; rxf_first = 1'b1; rxf_last = 1'b0;
        rxf_data = mkhdr(3'd5, 4'hA, 4'hC, 4'd3, 4'd9);
        chk(rxf_ready, "R9 flit ready idle", rxf_ready, 1);
        @(negedge clk);
        rxf_valid = 1'b0;
        chk(!rx_valid, "R8 not valid after header", rx_valid, 0);
        @(negedge clk);
        chk(!rx_valid, "R8 not valid in gap", rx_valid, 0);
        rxf_valid = 1'b1; rxf_first = 1'b0; rxf_last = 1'b1; rxf_data = 32'hDEAD_BEEF;
        @(negedge clk);
        rxf_valid = 1'b1; rxf_first = 1'b1; rxf_last = 1'b1;
        rxf_data = mkhdr(3'd0, 4'h1, 4'h1, 4'd3, 4'd1);
        chk(rx_valid && rx_addr == 32'hDEAD_BEEF, "R8 rebuilt address",
            {rx_valid, rx_addr}, {1'b1, 32'hDEAD_BEEF});
        chk(rx_snp == 4'hA && rx_prot == 3'd5 && rx_tid == 4'hC && rx_src == 4'd9,
            "R8 rebuilt fields", {rx_snp, rx_prot, rx_tid, rx_src},
            {4'hA, 3'd5, 4'hC, 4'd9});
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(rx_valid && !rxf_ready && rx_tid == 4'hC && rx_src == 4'd9 &&
                rx_addr == 32'hDEAD_BEEF, "R9 held beat",
                {rx_valid, rxf_ready, rx_tid, rx_src}, {2'b10, 4'hC, 4'd9});
        end
        rxf_valid = 1'b0;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk(!rx_valid && rxf_ready, "R9 release", {rx_valid, rxf_ready}, 2'b01);

        // back-to-back receive packet after release
        rxf_valid = 1'b1; rxf_first = 1'b1; rxf_last = 1'b0;
        rxf_data = mkhdr(3'd3, 4'h4, 4'h2, 4'd3, 4'd6);
        @(negedge clk);
        rxf_first = 1'b0; rxf_last = 1'b1; rxf_data = 32'h0000_1234;
        @(negedge clk);
        rxf_valid = 1'b0;
        chk(rx_valid && rx_addr == 32'h0000_1234 && rx_tid == 4'h2 && rx_src == 4'd6,
            "R8 second packet", {rx_addr, rx_tid, rx_src}, {32'h0000_1234, 4'h2, 4'd6});

        // R10 reset clears held state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!rx_valid && rxf_ready && tx_ready && !txf_valid, "R10 reset again",
            {rx_valid, rxf_ready, tx_ready, txf_valid}, 4'b0110);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule